// File: doc/BRIEF.md
# Offset Min-Sum Check Node Processor

This block computes the check-to-variable messages for one check node of a layered LDPC decoder. Signed 6-bit messages arrive one per cycle. A start flag marks the first message of a node and an end flag marks the last one, so the node degree is set at run time. While the messages arrive, the block reduces their magnitudes to a single pass of state: the smallest value, the runner-up, the position of the smallest and the parity of all sign bits. Each sign bit also goes into a small RAM.

After the final input the block is busy. It then emits one message per input, in the order the inputs arrived. Each output is built from every input of the node except the one in its own position. Before any comparison, each magnitude has a fixed offset of 1 subtracted and is clamped to the range 0..31. Nodes with fewer than two inputs, or with more inputs than the sign RAM holds, are dropped and flagged.

Top module: `cnode_minsum`

## Requirements
- R1: After reset, out_valid, out_last, busy and node_err are all low.
- R2: Each input x is first mapped to t(x) = min(max(|x| - 1, 0), 31). For example -32 maps to 31, 31 maps to 30, and 0, 1 and -1 all map to 0.
- R3: The magnitude of output i is the minimum of t over all inputs of the node except input i. When several inputs share the minimum, every output still excludes only its own position.
- R4: The sign of output i is the product of the signs of all other inputs; a zero input counts as positive. Output data is two's complement of the signed magnitude. It is therefore never -32 (6'b100000), and a zero magnitude gives 0.
- R5: A node of degree n produces exactly n outputs on consecutive cycles, in input order, with out_last on the n-th only. The first output appears two clock edges after the edge that accepted the last input.
- R6: busy rises on the edge that accepts a valid last input and falls on the edge that presents out_last. While busy is high, input beats are ignored.
- R7: A node whose start beat also carries the end flag (degree 1) produces no outputs. It raises node_err for one cycle and leaves busy low.
- R8: A node with more than MAX_DEG inputs (default 32) produces no outputs and raises node_err for one cycle.
- R9: For a degree-2 node, each output comes from exactly the other input.
- R10: An input beat without the start flag, arriving when no node is open, is ignored. A start beat in the middle of a node discards the partial node and begins a new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_first | input | 1 | Beat is the first of a node |
| in_last | input | 1 | Beat is the last of a node |
| in_data | input | DATA_W | Incoming message, two's complement |
| busy | output | 1 | Output pass in progress; inputs are ignored |
| node_err | output | 1 | One-cycle pulse: node rejected for its degree |
| out_valid | output | 1 | Output message present |
| out_last | output | 1 | Final output message of the node |
| out_data | output | DATA_W | Outgoing message, two's complement |

## Verification
The hardest situation to reach is an exact tie for the smallest transformed magnitude. In that case the runner-up must equal the minimum, and a strict-versus-non-strict compare slip changes only the output at the minimum's position. The stimulus reaches it in two ways. Some nodes draw all magnitudes from a tiny set, including values that clamp to zero. Other nodes repeat a single magnitude across the full degree of 32. Junk beats with start and end flags are injected during the busy window, next to stray beats and a mid-node restart. Any leak of these beats shows up as an unexpected error pulse or extra output.

// File: rtl/cnode_pkg.sv
package cnode_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_DRAIN   = 2'd2
  } cn_state_t;
endpackage

// File: rtl/cn_mag_xform.sv
module cn_mag_xform #(
  parameter int DATA_W  = 6,
  parameter int MAG_W   = 5,
  parameter int MAG_MAX = 31,
  parameter int OFFSET  = 1
) (
  input  logic [DATA_W-1:0] din,
  output logic [MAG_W-1:0]  mag
);
  localparam logic [DATA_W:0] OFF_V = (DATA_W+1)'(OFFSET);
  localparam logic [DATA_W:0] CAP_V = (DATA_W+1)'(MAG_MAX);

  logic [DATA_W:0] ext, absv, red;

  always_comb begin
    ext  = {din[DATA_W-1], din};
    absv = din[DATA_W-1] ? (~ext + 1'b1) : ext;
  end

  generate
    if (OFFSET == 0) begin : g_no_off
      assign red = absv;
    end else begin : g_off
      assign red = (absv > OFF_V) ? (absv - OFF_V) : '0;
    end
  endgenerate

  assign mag = (red > CAP_V) ? CAP_V[MAG_W-1:0] : red[MAG_W-1:0];
endmodule

// File: rtl/cn_min_track.sv
module cn_min_track #(
  parameter int MAG_W   = 5,
  parameter int MAG_MAX = 31,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             upd,
  input  logic [MAG_W-1:0] mag,
  input  logic [IDX_W-1:0] idx,
  input  logic             sgn,
  output logic [MAG_W-1:0] min1,
  output logic [MAG_W-1:0] min2,
  output logic [IDX_W-1:0] min1_idx,
  output logic             sgn_all
);
  localparam logic [MAG_W-1:0] TOP = MAG_W'(MAG_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      min1     <= TOP;
      min2     <= TOP;
      min1_idx <= '0;
      sgn_all  <= 1'b0;
    end else if (start) begin
      min1     <= mag;
      min2     <= TOP;
      min1_idx <= idx;
      sgn_all  <= sgn;
    end else if (upd) begin
      sgn_all <= sgn_all ^ sgn;
      if (mag < min1) begin
        min2     <= min1;
        min1     <= mag;
        min1_idx <= idx;
      end else if (mag < min2) begin
        min2 <= mag;
      end
    end
  end
endmodule

// File: rtl/cn_sign_ram.sv
module cn_sign_ram #(
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cnode_minsum.sv
module cnode_minsum
  import cnode_pkg::*;
#(
  parameter int DATA_W  = 6,
  parameter int MAG_MAX = 31,
  parameter int OFFSET  = 1,
  parameter int MAX_DEG = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [DATA_W-1:0] in_data,
  output logic              busy,
  output logic              node_err,
  output logic              out_valid,
  output logic              out_last,
  output logic [DATA_W-1:0] out_data
);
  localparam int MAG_W = $clog2(MAG_MAX + 1);
  localparam int IDX_W = $clog2(MAX_DEG);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] DEG_LIM = CNT_W'(MAX_DEG);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO     = CNT_W'(2);

  cn_state_t state;
  logic [CNT_W-1:0] wr_cnt, cur_idx, new_cnt, node_cnt, rd_cnt;
  logic take_first, take_next, take, in_range, bad_deg, issue;
  logic [MAG_W-1:0] in_mag, min1, min2, sel_mag;
  logic [IDX_W-1:0] min1_idx, s1_idx;
  logic sgn_all, s1_vld, s1_last, rd_sgn;
  logic [DATA_W-1:0] mag_ext;

  // Input-side control
  always_comb begin
    take_first = in_valid && (state != ST_DRAIN) && in_first;
    take_next  = in_valid && (state == ST_COLLECT) && !in_first;
    take       = take_first || take_next;
    cur_idx    = take_first ? '0 : wr_cnt;
    new_cnt    = cur_idx + ONE;
    in_range   = (cur_idx < DEG_LIM);
    bad_deg    = (new_cnt < TWO) || !in_range;
    issue      = (state == ST_DRAIN) && (rd_cnt < node_cnt);
  end

  cn_mag_xform #(
    .DATA_W(DATA_W), .MAG_W(MAG_W), .MAG_MAX(MAG_MAX), .OFFSET(OFFSET)
  ) u_xform (
    .din(in_data),
    .mag(in_mag)
  );

  cn_min_track #(
    .MAG_W(MAG_W), .MAG_MAX(MAG_MAX), .IDX_W(IDX_W)
  ) u_track (
    .clk     (clk),
    .rst     (rst),
    .start   (take_first),
    .upd     (take_next && in_range),
    .mag     (in_mag),
    .idx     (cur_idx[IDX_W-1:0]),
    .sgn     (in_data[DATA_W-1]),
    .min1    (min1),
    .min2    (min2),
    .min1_idx(min1_idx),
    .sgn_all (sgn_all)
  );

  cn_sign_ram #(
    .DEPTH(MAX_DEG), .AW(IDX_W)
  ) u_sgn (
    .clk  (clk),
    .we   (take && in_range),
    .waddr(cur_idx[IDX_W-1:0]),
    .wdata(in_data[DATA_W-1]),
    .re   (issue),
    .raddr(rd_cnt[IDX_W-1:0]),
    .rdata(rd_sgn)
  );

  // Node sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      wr_cnt   <= '0;
      node_cnt <= '0;
      rd_cnt   <= '0;
      node_err <= 1'b0;
      s1_vld   <= 1'b0;
      s1_last  <= 1'b0;
      s1_idx   <= '0;
    end else begin
      node_err <= take && in_last && bad_deg;
      if (take) begin
        wr_cnt <= in_range ? new_cnt : wr_cnt;
        if (in_last) begin
          state    <= bad_deg ? ST_IDLE : ST_DRAIN;
          node_cnt <= new_cnt;
          rd_cnt   <= '0;
        end else begin
          state <= ST_COLLECT;
        end
      end
      s1_vld  <= issue;
      s1_idx  <= rd_cnt[IDX_W-1:0];
      s1_last <= issue && (rd_cnt == node_cnt - ONE);
      if (issue) rd_cnt <= rd_cnt + ONE;
      if (s1_vld && s1_last) state <= ST_IDLE;
    end
  end

  // Output assembly
  always_comb begin
    sel_mag = (s1_idx == min1_idx) ? min2 : min1;
    mag_ext = DATA_W'(sel_mag);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_vld;
      out_last  <= s1_vld && s1_last;
      out_data  <= (sgn_all ^ rd_sgn) ? (~mag_ext + 1'b1) : mag_ext;
    end
  end

  assign busy = (state == ST_DRAIN);
endmodule

// File: rtl/cnode_minsum_chk.sv
module cnode_minsum_chk #(
  parameter int DATA_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_last,
  input logic              busy,
  input logic              node_err,
  input logic              out_valid,
  input logic              out_last,
  input logic [DATA_W-1:0] out_data
);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  assert_no_most_neg_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data != MOST_NEG));

  assert_last_ends_R5: assert property (@(posedge clk) disable iff (rst)
    out_last |=> !out_valid);

  assert_busy_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(in_valid && in_last));

  assert_busy_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> out_last);

  assert_err_idle_R7: assert property (@(posedge clk) disable iff (rst)
    node_err |-> !busy);

  assert_last_valid_R5: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
endmodule

bind cnode_minsum cnode_minsum_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
  .busy(busy), .node_err(node_err), .out_valid(out_valid),
  .out_last(out_last), .out_data(out_data)
);

// File: tb/tb_cnode_minsum.sv
`timescale 1ns/1ps
module tb_cnode_minsum;
  localparam int DW = 6;
  localparam int MAXD = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_first = 0, in_last = 0;
  logic [DW-1:0] in_data = '0;
  logic busy, node_err, out_valid, out_last;
  logic [DW-1:0] out_data;

  always #10 clk = ~clk;

  cnode_minsum dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_data(in_data), .busy(busy), .node_err(node_err),
    .out_valid(out_valid), .out_last(out_last), .out_data(out_data)
  );

  int checks = 0, fails = 0, err_exp = 0;
  bit done = 0;
  logic [DW:0] exp_q [$];

  function automatic int tmag(int x);
    int a = (x < 0) ? -x : x;
    a = a - 1;
    if (a < 0) a = 0;
    if (a > 31) a = 31;
    return a;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) chk(0, "R5 unexpected output", int'(out_data), -1);
      else begin
        logic [DW:0] e;
        e = exp_q.pop_front();
        chk(out_data == e[DW-1:0], "R3 R4 data", int'($signed(out_data)),
            int'($signed(e[DW-1:0])));
        chk(out_last == e[DW], "R5 last flag", int'(out_last), int'(e[DW]));
      end
    end
    if (!rst && node_err) begin
      chk(err_exp > 0, "R7 R8 unexpected error pulse", 1, 0);
      if (err_exp > 0) err_exp--;
    end
  end

  task automatic send_node(input int v[], input bit junk, input bit lat);
    int n = v.size();
    if (n >= 2 && n <= MAXD) begin
      for (int i = 0; i < n; i++) begin
        int m = 31, s = 0, o;
        for (int j = 0; j < n; j++)
          if (j != i) begin
            if (tmag(v[j]) < m) m = tmag(v[j]);
            s ^= (v[j] < 0);
          end
        o = s ? -m : m;
        exp_q.push_back({(i == n - 1), DW'(o)});
      end
    end else err_exp++;
    while (busy) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_first = (i == 0); in_last = (i == n - 1);
      in_data = DW'(v[i]);
    end
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0;
    if (lat) begin
      chk(busy == 1, "R6 busy after last", int'(busy), 1);
      chk(out_valid == 0, "R5 no output yet", int'(out_valid), 0);
      @(negedge clk);
      chk(out_valid == 0, "R5 no output one edge on", int'(out_valid), 0);
      @(negedge clk);
      chk(out_valid == 1, "R5 first output two edges on", int'(out_valid), 1);
    end
    if (junk) begin
      for (int k = 0; k < 2; k++) begin
        if (busy) begin
          in_valid = 1; in_first = 1; in_last = 1; in_data = 6'h21;
        end
        @(negedge clk);
        in_valid = 0; in_first = 0; in_last = 0;
      end
    end
  endtask

  task automatic drain();
    int t = 0;
    while ((exp_q.size() != 0 || busy) && t < 500) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v[];
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
    chk(out_last == 0, "R1 out_last", int'(out_last), 0);
    chk(busy == 0, "R1 busy", int'(busy), 0);
    chk(node_err == 0, "R1 node_err", int'(node_err), 0);

    // R9 degree two, with R5 latency
    v = '{5, -9};
    send_node(v, 0, 1);
    drain();
    // R2 transform extremes and zero
    v = '{-32, 31, 0, 1, -1, 2};
    send_node(v, 0, 0);
    drain();
    // R7 degree one
    v = '{7};
    send_node(v, 0, 0);
    repeat (2) @(negedge clk);
    chk(busy == 0, "R7 busy stays low", int'(busy), 0);
    // R8 over-degree
    v = new[MAXD + 1];
    foreach (v[i]) v[i] = i - 16;
    send_node(v, 0, 0);
    drain();
    // R3 full degree, all tied magnitudes
    v = new[MAXD];
    foreach (v[i]) v[i] = (i % 3 == 0) ? -6 : 6;
    send_node(v, 0, 0);
    drain();
    // R6 junk beats during busy
    v = '{3, -4, 12, -20, 9};
    send_node(v, 1, 0);
    drain();
    // R10 stray beats while idle, then mid-node restart
    @(negedge clk);
    in_valid = 1; in_first = 0; in_last = 1; in_data = 6'd9;
    @(negedge clk);
    in_valid = 0; in_last = 0;
    for (int i = 0; i < 3; i++) begin
      in_valid = 1; in_first = (i == 0); in_data = 6'h3F;
      @(negedge clk);
    end
    in_valid = 0; in_first = 0;
    v = '{10, -11, 12};
    send_node(v, 0, 0);
    drain();
    // R3 R4 random nodes, some from a tiny magnitude set to force ties
    for (int r = 0; r < 40; r++) begin
      int n = 2 + int'($urandom_range(30));
      v = new[n];
      foreach (v[i])
        v[i] = (r % 2) ? (int'($urandom_range(4)) - 2)
                       : (int'($urandom_range(63)) - 32);
      send_node(v, 0, 0);
    end
    drain();
    chk(exp_q.size() == 0, "R5 all outputs seen", exp_q.size(), 0);
    chk(err_exp == 0, "R7 R8 all error pulses seen", err_exp, 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule